// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block sits between a CAN protocol engine and the host. Each time the engine hands over a complete frame (identifier, extended flag, remote flag, length code and eight data bytes), the allocator chooses one receive mailbox to hold it. It compares the frame against the identifier filter of every mailbox at once. It prefers an empty mailbox and avoids destroying unread contents that the host has protected. It then writes the frame into the chosen mailbox and updates the per-mailbox pending and lost flags.

The host works through a small word-addressed register port. It programs the filter word and local mask of each mailbox, and it sets the enable, direction and protection vectors. It reads stored frames back and clears the pending flags, the lost flags and the lost interrupt by writing ones. Every frame decision produces a one-cycle result pulse, either "stored" (with the mailbox index and an overwrite flag) or "dropped". The surrounding logic can count or route frames from that pulse.

Address map, word addressed, with `ADDR_W = log2(NUM_MB) + 4`. When the top address bit is 0 the port selects a global register, picked by bits 2:0:
- 0: enable
- 1: direction (1 = receive)
- 2: protect
- 3: pending (write 1 to clear)
- 4: lost (write 1 to clear)
- 5: lost interrupt, bit 0 (write 1 to clear)

When the top address bit is 1, bits `MB_AW+2:3` give the mailbox and bits 2:0 pick the field:
- 0: filter word (read/write)
- 1: local mask (read/write)
- 2: received identifier word
- 3: control word
- 4: data bytes 0 to 3, with byte 0 in bits 31:24
- 5: data bytes 4 to 7

Top module: `can_rx_mailbox_alloc`

## Requirements
- R1: After a synchronous reset the enable, direction, protect, pending and lost vectors and the lost interrupt all read 0, and no result pulse is produced.
- R2: An identifier word carries the extended flag in bit 31, a 29-bit extended identifier in bits 28:0, and an 11-bit standard identifier in bits 28:18. With bit 30 of the filter word clear, a mailbox matches only when the extended flag is equal and the identifier bits are equal. Bits 28:0 are compared for an extended frame and bits 28:18 for a standard frame.
- R3: With bit 30 of the filter word set, a 1 in the local mask makes the corresponding identifier bit (and bit 31 for the extended flag) a don't-care. A mask of all ones accepts every frame.
- R4: A mailbox can take a frame only if its enable bit and its direction bit are both 1 and its filter matches. Among such mailboxes whose pending bit is 0, the highest-numbered one is chosen.
- R5: An eligible mailbox whose pending bit is 1 is passed over while any lower eligible mailbox is empty.
- R6: When every eligible mailbox is pending, the frame overwrites the highest-numbered eligible mailbox whose protect bit is 0. That mailbox's lost bit and the lost interrupt are set, and the result pulse carries the overwrite flag.
- R7: When no mailbox is eligible, or every eligible one is both pending and protected, the frame is dropped. A drop pulse is produced and no pending, lost or stored content changes.
- R8: A stored mailbox returns the following on host reads:
  - the received identifier word in R2's layout;
  - a control word with the length code in bits 3:0 and the remote flag in bit 4;
  - the data bytes.
  Read data appears in the cycle after the read request.
- R9: Storing a frame sets the chosen mailbox's pending bit. Writing 1 to a pending bit clears it, and a frame stored in the same cycle wins.
- R10: Writing 1 to a lost bit clears it. Writing 1 to bit 0 of the lost interrupt register clears the interrupt.
- R11: A write to the enable vector takes effect on a frame presented in the very next cycle.
- R12: The stored or dropped pulse, with its index and overwrite flag, is registered and appears in the cycle after the frame is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is presented |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Remote frame |
| frm_dlc | input | 4 | Length code |
| frm_id | input | 29 | Identifier; a standard identifier sits in bits 10:0 |
| frm_data | input | 64 | Data, byte 0 in bits 63:56 |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| pend_o | output | NUM_MB | Pending vector |
| lost_o | output | NUM_MB | Lost vector |
| lost_irq_o | output | 1 | Lost interrupt |
| store_o | output | 1 | Frame was stored |
| store_idx_o | output | MB_AW | Mailbox that received the frame |
| ovw_o | output | 1 | The store overwrote unread contents |
| drop_o | output | 1 | Frame was discarded |

## Verification
The assertions assume several things about the inputs:
- `frm_valid` is a strobe whose frame fields are stable in the presented cycle.
- The host never addresses a mailbox index at or above `NUM_MB`.
- The lost interrupt falls only because of a host write.

The bench drives frames and register accesses on the falling edge, one operation at a time, and never issues a host read of a mailbox in the same cycle that a frame is written into it. It keeps the configured mailbox indices inside the parameterised count.

// File: rtl/can_rxmb_pkg.sv
package can_rxmb_pkg;

  // stored image of one received frame
  typedef struct packed {
    logic        ext;
    logic        rtr;
    logic [3:0]  dlc;
    logic [28:0] id;
    logic [63:0] data;
  } rx_frame_t;

  // global register selectors (address bits 2:0, top address bit 0)
  typedef enum logic [2:0] {
    G_ENABLE  = 3'd0,
    G_DIR     = 3'd1,
    G_PROTECT = 3'd2,
    G_PEND    = 3'd3,
    G_LOST    = 3'd4,
    G_IRQ     = 3'd5
  } glob_sel_e;

  // mailbox field selectors (address bits 2:0, top address bit 1)
  typedef enum logic [2:0] {
    M_FILTER = 3'd0,
    M_MASK   = 3'd1,
    M_RXID   = 3'd2,
    M_CTRL   = 3'd3,
    M_DLO    = 3'd4,
    M_DHI    = 3'd5
  } mb_sel_e;

  // place a frame identifier into the 32-bit identifier word layout
  function automatic logic [31:0] id_word(input logic ext, input logic [28:0] id);
    if (ext) id_word = {1'b1, 2'b00, id};
    else     id_word = {1'b0, 2'b00, id[10:0], 18'd0};
  endfunction

endpackage

// File: rtl/rxmb_filter.sv
module rxmb_filter #(
  parameter int NUM_MB = 8
) (
  input  logic [31:0]              frame_word,
  input  logic                     frame_ext,
  input  logic [NUM_MB-1:0][31:0]  filt,
  input  logic [NUM_MB-1:0][31:0]  mask,
  output logic [NUM_MB-1:0]        hit
);
  localparam logic [31:0] CARE_EXT = 32'h9FFF_FFFF;
  localparam logic [31:0] CARE_STD = 32'h9FFC_0000;

  logic [31:0] base_care;
  assign base_care = frame_ext ? CARE_EXT : CARE_STD;

  for (genvar m = 0; m < NUM_MB; m++) begin : g_cmp
    logic [31:0] care;
    assign care   = filt[m][30] ? (base_care & ~mask[m]) : base_care;
    assign hit[m] = ((frame_word ^ filt[m]) & care) == 32'd0;
  end
endmodule

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // later (higher) indices overwrite earlier ones: highest request wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store #(
  parameter int DEPTH = 8,
  parameter int W     = 99,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/can_rx_mailbox_alloc.sv
module can_rx_mailbox_alloc
  import can_rxmb_pkg::*;
#(
  parameter  int NUM_MB = 8,
  localparam int MB_AW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int ADDR_W = MB_AW + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_valid,
  input  logic              frm_ext,
  input  logic              frm_rtr,
  input  logic [3:0]        frm_dlc,
  input  logic [28:0]       frm_id,
  input  logic [63:0]       frm_data,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic [NUM_MB-1:0] pend_o,
  output logic [NUM_MB-1:0] lost_o,
  output logic              lost_irq_o,
  output logic              store_o,
  output logic [MB_AW-1:0]  store_idx_o,
  output logic              ovw_o,
  output logic              drop_o
);
  localparam int FRAME_W = $bits(rx_frame_t);

  // configuration and status state
  logic [NUM_MB-1:0]       en_q, dir_q, prot_q, pend_q, lost_q;
  logic                    irq_q;
  logic [NUM_MB-1:0][31:0] filt_q, mask_q;

  // host decode
  logic             h_mb;
  logic [MB_AW-1:0] h_idx;
  logic [2:0]       h_fld;
  logic             h_idx_ok;
  assign h_mb     = host_addr[ADDR_W-1];
  assign h_idx    = host_addr[MB_AW+2:3];
  assign h_fld    = host_addr[2:0];
  assign h_idx_ok = 32'(h_idx) < NUM_MB;

  logic gw;
  assign gw = host_wr && !h_mb;

  // filtering and allocation
  logic [31:0]       frame_word;
  logic [NUM_MB-1:0] hit, elig, empty_req, ovw_req;
  logic              e_found, o_found;
  logic [MB_AW-1:0]  e_idx, o_idx, sel_idx;
  logic              take_empty, take_ovw, do_store;

  assign frame_word = id_word(frm_ext, frm_id);

  rxmb_filter #(.NUM_MB(NUM_MB)) u_filter (
    .frame_word (frame_word),
    .frame_ext  (frm_ext),
    .filt       (filt_q),
    .mask       (mask_q),
    .hit        (hit)
  );

  assign elig      = hit & en_q & dir_q;
  assign empty_req = elig & ~pend_q;
  assign ovw_req   = elig & pend_q & ~prot_q;

  rxmb_pick #(.N(NUM_MB), .IW(MB_AW)) u_pick_empty (
    .req (empty_req), .found (e_found), .idx (e_idx)
  );
  rxmb_pick #(.N(NUM_MB), .IW(MB_AW)) u_pick_ovw (
    .req (ovw_req), .found (o_found), .idx (o_idx)
  );

  assign take_empty = frm_valid && e_found;
  assign take_ovw   = frm_valid && !e_found && o_found;
  assign do_store   = take_empty || take_ovw;
  assign sel_idx    = e_found ? e_idx : o_idx;

  // next-state of the flag vectors: a store beats a same-cycle clear
  logic [NUM_MB-1:0] pend_d, lost_d;
  logic              irq_d;
  always_comb begin
    pend_d = pend_q;
    lost_d = lost_q;
    irq_d  = irq_q;
    if (gw && h_fld == G_PEND) pend_d = pend_d & ~host_wdata[NUM_MB-1:0];
    if (gw && h_fld == G_LOST) lost_d = lost_d & ~host_wdata[NUM_MB-1:0];
    if (gw && h_fld == G_IRQ && host_wdata[0]) irq_d = 1'b0;
    if (do_store) pend_d[sel_idx] = 1'b1;
    if (take_ovw) begin
      lost_d[sel_idx] = 1'b1;
      irq_d           = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      dir_q  <= '0;
      prot_q <= '0;
      pend_q <= '0;
      lost_q <= '0;
      irq_q  <= 1'b0;
      filt_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      lost_q <= lost_d;
      irq_q  <= irq_d;
      if (gw && h_fld == G_ENABLE)  en_q   <= host_wdata[NUM_MB-1:0];
      if (gw && h_fld == G_DIR)     dir_q  <= host_wdata[NUM_MB-1:0];
      if (gw && h_fld == G_PROTECT) prot_q <= host_wdata[NUM_MB-1:0];
      if (host_wr && h_mb && h_idx_ok) begin
        if (h_fld == M_FILTER) filt_q[h_idx] <= host_wdata;
        if (h_fld == M_MASK)   mask_q[h_idx] <= host_wdata;
      end
    end
  end

  // result pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      store_o     <= 1'b0;
      store_idx_o <= '0;
      ovw_o       <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      store_o     <= do_store;
      store_idx_o <= do_store ? sel_idx : '0;
      ovw_o       <= take_ovw;
      drop_o      <= frm_valid && !do_store;
    end
  end

  // frame storage
  rx_frame_t wr_frame, rd_frame;
  logic [FRAME_W-1:0] rd_raw;
  assign wr_frame = '{ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc, id: frm_id, data: frm_data};
  assign rd_frame = rx_frame_t'(rd_raw);

  rxmb_store #(.DEPTH(NUM_MB), .W(FRAME_W), .AW(MB_AW)) u_store (
    .clk   (clk),
    .we    (do_store),
    .waddr (sel_idx),
    .wdata (FRAME_W'(wr_frame)),
    .raddr (h_idx),
    .rdata (rd_raw)
  );

  // read path: register selection and small registers, memory is read in step
  logic [31:0] reg_val, reg_q;
  logic        rmb_q, rvalid_q;
  logic [2:0]  rfld_q;

  always_comb begin
    reg_val = 32'd0;
    if (h_mb) begin
      if (h_idx_ok && h_fld == M_FILTER) reg_val = filt_q[h_idx];
      if (h_idx_ok && h_fld == M_MASK)   reg_val = mask_q[h_idx];
    end else begin
      case (h_fld)
        G_ENABLE:  reg_val = 32'(en_q);
        G_DIR:     reg_val = 32'(dir_q);
        G_PROTECT: reg_val = 32'(prot_q);
        G_PEND:    reg_val = 32'(pend_q);
        G_LOST:    reg_val = 32'(lost_q);
        G_IRQ:     reg_val = {31'd0, irq_q};
        default:   reg_val = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rmb_q    <= 1'b0;
      rfld_q   <= '0;
      reg_q    <= '0;
    end else begin
      rvalid_q <= host_rd;
      if (host_rd) begin
        rmb_q  <= h_mb;
        rfld_q <= h_fld;
        reg_q  <= reg_val;
      end
    end
  end

  always_comb begin
    host_rdata = reg_q;
    if (rmb_q) begin
      case (rfld_q)
        M_RXID:  host_rdata = id_word(rd_frame.ext, rd_frame.id);
        M_CTRL:  host_rdata = {27'd0, rd_frame.rtr, rd_frame.dlc};
        M_DLO:   host_rdata = rd_frame.data[63:32];
        M_DHI:   host_rdata = rd_frame.data[31:0];
        default: host_rdata = reg_q;
      endcase
    end
  end

  assign host_rvalid = rvalid_q;
  assign pend_o      = pend_q;
  assign lost_o      = lost_q;
  assign lost_irq_o  = irq_q;
endmodule

// File: rtl/can_rx_mailbox_alloc_chk.sv
module can_rx_mailbox_alloc_chk #(
  parameter int NUM_MB = 8,
  parameter int MB_AW  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_valid,
  input logic              host_wr,
  input logic [NUM_MB-1:0] pend_o,
  input logic [NUM_MB-1:0] lost_o,
  input logic              lost_irq_o,
  input logic              store_o,
  input logic [MB_AW-1:0]  store_idx_o,
  input logic              ovw_o,
  input logic              drop_o
);
  logic [NUM_MB-1:0] pend_prev;
  always_ff @(posedge clk) begin
    if (rst) pend_prev <= '0;
    else     pend_prev <= pend_o;
  end

  // R12
  result_needs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (store_o || drop_o) |-> $past(frm_valid));

  // R7
  store_drop_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(store_o && drop_o));

  // R9
  store_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    store_o |-> pend_o[store_idx_o]);

  // R9
  pend_rise_only_by_store_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_o & ~pend_prev) != '0) |-> (store_o && $onehot(pend_o & ~pend_prev)));

  // R5
  fresh_store_was_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (store_o && !ovw_o) |-> !pend_prev[store_idx_o]);

  // R6
  overwrite_marks_lost_chk: assert property (@(posedge clk) disable iff (rst)
    (store_o && ovw_o) |-> (pend_prev[store_idx_o] && lost_o[store_idx_o] && lost_irq_o));

  // R10
  irq_falls_by_host_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lost_irq_o) |-> $past(host_wr));
endmodule

bind can_rx_mailbox_alloc can_rx_mailbox_alloc_chk #(.NUM_MB(NUM_MB), .MB_AW(MB_AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frm_valid   (frm_valid),
  .host_wr     (host_wr),
  .pend_o      (pend_o),
  .lost_o      (lost_o),
  .lost_irq_o  (lost_irq_o),
  .store_o     (store_o),
  .store_idx_o (store_idx_o),
  .ovw_o       (ovw_o),
  .drop_o      (drop_o)
);

// File: tb/tb_can_rx_mailbox_alloc.sv
`timescale 1ns/1ps
module tb_can_rx_mailbox_alloc;
  localparam int NUM_MB = 8;
  localparam int MB_AW  = 3;
  localparam int ADDR_W = MB_AW + 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
  logic [3:0]        frm_dlc = '0;
  logic [28:0]       frm_id = '0;
  logic [63:0]       frm_data = '0;
  logic              host_wr = 1'b0, host_rd = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0]       host_wdata = '0;
  logic [31:0]       host_rdata;
  logic              host_rvalid;
  logic [NUM_MB-1:0] pend_o, lost_o;
  logic              lost_irq_o, store_o, ovw_o, drop_o;
  logic [MB_AW-1:0]  store_idx_o;

  always #4 clk = ~clk;  // 125 MHz

  can_rx_mailbox_alloc #(.NUM_MB(NUM_MB)) dut (.*);

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // bench-side model of the programmed state
  logic [NUM_MB-1:0] m_en = '0, m_dir = '0, m_prot = '0, m_pend = '0, m_lost = '0;
  logic [31:0] m_filt [NUM_MB];
  logic [31:0] m_mask [NUM_MB];
  initial for (int i = 0; i < NUM_MB; i++) begin m_filt[i] = '0; m_mask[i] = '0; end

  typedef struct { int code; string req; } exp_t;  // code: -1 drop, idx, idx+100 overwrite
  exp_t exp_q[$];

  function automatic logic [ADDR_W-1:0] ga(input int f);
    return ADDR_W'(f);
  endfunction
  function automatic logic [ADDR_W-1:0] ma(input int m, input int f);
    return ADDR_W'(64 + m * 8 + f);
  endfunction

  task automatic hw(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    if (a[ADDR_W-1]) begin
      if (a[2:0] == 3'd0) m_filt[a[5:3]] = d;
      if (a[2:0] == 3'd1) m_mask[a[5:3]] = d;
    end else begin
      case (a[2:0])
        3'd0: m_en   = d[NUM_MB-1:0];
        3'd1: m_dir  = d[NUM_MB-1:0];
        3'd2: m_prot = d[NUM_MB-1:0];
        3'd3: m_pend = m_pend & ~d[NUM_MB-1:0];
        3'd4: m_lost = m_lost & ~d[NUM_MB-1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R8 rvalid", {31'd0, host_rvalid}, 32'd1);
    d = host_rdata;
  endtask

  function automatic bit bm_match(input int m, input bit ext, input logic [28:0] id);
    logic [31:0] w, care;
    w    = ext ? {1'b1, 2'b00, id} : {1'b0, 2'b00, id[10:0], 18'd0};
    care = ext ? 32'h9FFF_FFFF : 32'h9FFC_0000;
    if (m_filt[m][30]) care = care & ~m_mask[m];
    return ((w ^ m_filt[m]) & care) == 32'd0;
  endfunction

  // driver: computes the expected decision and pushes it to the scoreboard
  task automatic frame(input bit ext, input logic [28:0] id, input bit rtr,
                       input logic [3:0] dlc, input logic [63:0] data, input string req);
    int code = -1;
    exp_t e;
    for (int m = NUM_MB - 1; m >= 0 && code < 0; m--)
      if (m_en[m] && m_dir[m] && bm_match(m, ext, id) && !m_pend[m]) code = m;
    for (int m = NUM_MB - 1; m >= 0 && code < 0; m--)
      if (m_en[m] && m_dir[m] && bm_match(m, ext, id) && !m_prot[m]) code = m + 100;
    if (code >= 100) begin m_pend[code-100] = 1'b1; m_lost[code-100] = 1'b1; end
    else if (code >= 0) m_pend[code] = 1'b1;
    e.code = code; e.req = req;
    @(negedge clk);
    exp_q.push_back(e);
    frm_valid = 1'b1; frm_ext = ext; frm_id = id; frm_rtr = rtr; frm_dlc = dlc; frm_data = data;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // monitor: pops and compares as results appear (R12: one cycle after the frame)
  always @(negedge clk) begin
    if (!rst && (store_o || drop_o)) begin
      int act;
      exp_t e;
      act = drop_o ? -1 : (int'(store_idx_o) + (ovw_o ? 100 : 0));
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected result actual=%0d expected=none", act);
      end else begin
        e = exp_q.pop_front();
        chk({e.req, " R12 decision"}, 32'(act), 32'(e.code));
      end
    end
  end

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    hr(ga(0), d); chk("R1 enable", d, 0);
    hr(ga(3), d); chk("R1 pending", d, 0);
    chk("R1 lost", 32'(lost_o), 0);
    chk("R1 irq", {31'd0, lost_irq_o}, 0);
    chk("R1 no result", {30'd0, store_o, drop_o}, 0);

    // mailboxes 4..7 accept everything
    for (int m = 4; m < 8; m++) begin
      hw(ma(m, 0), 32'h4000_0000);
      hw(ma(m, 1), 32'hFFFF_FFFF);
    end
    hw(ga(0), 32'hF0);
    hw(ga(1), 32'hF0);

    frame(0, 29'h2A5, 0, 4'd8, 64'h1122_3344_5566_7788, "R4 highest empty");
    frame(1, 29'h1234567, 1, 4'd2, 64'hAABB_0000_0000_0000, "R5 skip pending");

    // R8 stored contents
    hr(ma(7, 2), d); chk("R8 std id word", d, 32'h2A5 << 18);
    hr(ma(7, 3), d); chk("R8 ctrl", d, 32'h8);
    hr(ma(7, 4), d); chk("R8 data low", d, 32'h1122_3344);
    hr(ma(7, 5), d); chk("R8 data high", d, 32'h5566_7788);
    hr(ma(6, 2), d); chk("R8 ext id word", d, 32'h8000_0000 | 32'h1234567);
    hr(ma(6, 3), d); chk("R8 rtr ctrl", d, 32'h12);

    frame(0, 29'h10, 0, 4'd1, 64'h0, "R5 fill 5");
    frame(0, 29'h11, 0, 4'd1, 64'h0, "R5 fill 4");

    // R6 overwrite of highest unprotected pending
    hw(ga(2), 32'h30);
    frame(0, 29'h12, 0, 4'd3, 64'hCAFE_0000_0000_0000, "R6 overwrite");
    chk("R6 lost bit", 32'(lost_o), 32'h80);
    chk("R6 irq", {31'd0, lost_irq_o}, 1);
    hr(ma(7, 2), d); chk("R6 new contents", d, 32'h12 << 18);

    // R7 all protected and pending: dropped
    hw(ga(2), 32'hF0);
    frame(0, 29'h13, 0, 4'd0, 64'h0, "R7 drop");
    chk("R7 pend unchanged", 32'(pend_o), 32'hF0);
    chk("R7 lost unchanged", 32'(lost_o), 32'h80);

    // R9 pending clear
    hw(ga(3), 32'h40);
    chk("R9 w1c pend", 32'(pend_o), 32'hB0);
    frame(0, 29'h14, 0, 4'd0, 64'h0, "R9 refill 6");
    chk("R9 pend set", 32'(pend_o), 32'hF0);

    // R10 lost and irq clear
    hw(ga(4), 32'h80);
    chk("R10 lost clear", 32'(lost_o), 0);
    chk("R10 irq held", {31'd0, lost_irq_o}, 1);
    hw(ga(5), 32'h1);
    chk("R10 irq clear", {31'd0, lost_irq_o}, 0);

    // filter setups
    hw(ga(3), 32'hFF);
    hw(ga(2), 32'h0);
    hw(ma(3, 0), 32'h123 << 18);
    hw(ma(2, 0), 32'h8000_0000 | 32'h1ABCDEF);
    hw(ma(1, 0), 32'h4000_0000 | (32'h100 << 18));
    hw(ma(1, 1), 32'h0FF << 18);
    hw(ma(0, 0), 32'h4000_0000);
    hw(ma(0, 1), 32'hFFFF_FFFF);
    hw(ga(0), 32'h0F);
    hw(ga(1), 32'h0E);

    frame(0, 29'h123, 0, 4'd0, 64'h0, "R2 exact std");
    frame(0, 29'h1AB, 0, 4'd0, 64'h0, "R3 masked std");
    frame(1, 29'h1ABCDEF, 0, 4'd0, 64'h0, "R2 exact ext");
    frame(0, 29'h224, 0, 4'd0, 64'h0, "R4 direction excludes");
    frame(1, 29'h123 << 18, 0, 4'd0, 64'h0, "R2 ext flag compare");

    // R11 enable change seen by the very next frame
    hw(ga(3), 32'hFF);
    hw(ga(0), 32'h0B);
    frame(1, 29'h1ABCDEF, 0, 4'd0, 64'h0, "R11 disabled");
    hw(ga(0), 32'h0F);
    frame(1, 29'h1ABCDEF, 0, 4'd0, 64'h0, "R11 re-enabled");

    repeat (3) @(negedge clk);
    chk("R12 all results seen", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule